// File: doc/BRIEF.md
# Converter Parallel Result Port

This block is the device-side parallel output stage of a 16-bit sampling converter. It holds the most recent conversion result and presents it on a 16-bit data bus that the pad ring can tri-state. It does not contain the analog engine. That engine is represented by a result word, `conv_word`, and a one-cycle strobe, `conv_done`. The port drives a BUSY flag that is high while a conversion is running and while the port initializes after a device reset.

The host controls the bus with an active-low chip select and an active-low read strobe. The bus is driven only when both are low. When both are tied low, the host can read continuously, and the bus moves from the old result to the new one at the end of each conversion. The result register loads only when a conversion completes, so a read made while a conversion is running returns the previous sample.

Two static selects shape the output word:
- The coding select chooses offset binary or two's complement.
- The byte-swap select exchanges the two byte lanes, so an 8-bit host can fetch both halves from one lane.

A separate device-reset input runs a two-edge sequence:
1. Its rising edge aborts any conversion and releases the bus.
2. Its falling edge clears the result and raises BUSY for a fixed initialization pulse.

Top module: `conv_result_port`

## Requirements
- R1: `bus_oe` is 1 only when `sel_n` = 0, `rd_n` = 0, `dev_reset` = 0 and no reset hold is in progress. Otherwise it is 0 and `bus_val` reads 0.
- R2: With `twos_comp` = 0 the stored word is presented unchanged (offset binary). With `twos_comp` = 1, bit 15 (the MSB) of the stored word is inverted and the other bits are unchanged.
- R3: With `swap_bytes` = 0, stored bits [7:0] appear on `bus_val[7:0]` and bits [15:8] appear on `bus_val[15:8]`. With `swap_bytes` = 1 the two bytes exchange lanes.
- R4: While `dev_reset` is high the bus is released in the same cycle. A rising edge aborts a running conversion: BUSY drops, and a later `conv_done` does not load the result.
- R5: When `dev_reset` falls, the result register clears to zero. BUSY is then high for exactly INIT_CYCLES (default 4) consecutive cycles, starting in the cycle after the fall is sampled.
- R6: `conv_start` is accepted only while BUSY is low. A start that is held during initialization has no effect.
- R7: An accepted start raises BUSY in the next cycle. `conv_done` during a conversion loads `conv_word` and drops BUSY in the next cycle. While the conversion runs, the bus keeps showing the previous result.
- R8: A `conv_done` pulse outside a conversion leaves the stored result unchanged.
- R9: A low `rst_n` on a clock edge returns the port to idle, with BUSY low and the stored result zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| dev_reset | input | 1 | Device reset; its rising edge aborts and releases the bus, its falling edge clears and initializes |
| conv_start | input | 1 | Conversion start request |
| conv_done | input | 1 | One-cycle end-of-conversion strobe from the engine |
| conv_word | input | 16 | Straight-binary result from the engine |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| swap_bytes | input | 1 | Exchanges the two byte lanes when 1 |
| twos_comp | input | 1 | Selects two's-complement coding when 1 |
| bus_val | output | 16 | Value for the bus pads |
| bus_oe | output | 1 | Pad output enable; 0 means high impedance |
| busy | output | 1 | Conversion or initialization in progress |

## Verification
The assertions check on every cycle that the bus is released when the port is deselected or held in device reset. They also check that a completed conversion loads the engine word, that a stray done strobe leaves the result alone, and that a start during initialization never begins a conversion.

Some behaviours are seen only in the bench's scenarios:
- the exact length of the BUSY initialization pulse;
- all four combinations of coding and lane swap on real words;
- the previous result being visible while a conversion runs;
- an aborted conversion that stays unloaded after reset.

// File: rtl/crp_pkg.sv
// Package: shared phase encoding for the converter result port.
// Assumes: a single clock domain; all users import this package.
package crp_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_HOLD = 2'd2,
        PH_INIT = 2'd3
    } phase_t;
endpackage

// File: rtl/crp_seq.sv
// Module: crp_seq
// Sequences conversions and the device-reset handshake.
// A rising dev_reset edge aborts the current phase and holds.
// A falling edge requests a result clear and runs an initialization
// window of INIT_CYCLES cycles with busy high.
// Assumes: dev_reset is synchronous to clk; INIT_CYCLES >= 1.
module crp_seq
    import crp_pkg::*;
#(
    parameter int INIT_CYCLES = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   dev_reset,
    input  logic   conv_start,
    input  logic   conv_done,
    output phase_t phase,
    output logic   busy,
    output logic   load_en,
    output logic   clr_en,
    output logic   kill,
    output logic   rise
);
    localparam int CW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_START = CW'(INIT_CYCLES - 1);

    logic          dev_q;
    logic          fall;
    logic [CW-1:0] cnt;

    // Remember the previous device-reset level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dev_q <= 1'b0;
        else        dev_q <= dev_reset;
    end

    // Edge strobes on the device-reset input.
    always_comb begin
        rise = dev_reset & ~dev_q;
        fall = ~dev_reset & dev_q;
    end

    // Phase transitions and the initialization countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (rise) begin
            phase <= PH_HOLD;
        end else if (fall) begin
            phase <= PH_INIT;
            cnt   <= CNT_START;
        end else begin
            unique case (phase)
                PH_IDLE: if (conv_start) phase <= PH_CONV;
                PH_CONV: if (conv_done)  phase <= PH_IDLE;
                PH_HOLD: phase <= PH_HOLD;
                PH_INIT: begin
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Control strobes for the result register and the output stage.
    always_comb begin
        busy    = (phase == PH_CONV) || (phase == PH_INIT);
        load_en = (phase == PH_CONV) && conv_done && !rise && !fall;
        clr_en  = fall;
        kill    = dev_reset || (phase == PH_HOLD);
    end
endmodule

// File: rtl/crp_result_reg.sv
// Module: crp_result_reg
// Holds the last completed conversion word.
// Assumes: load and clr are never high together; if they are, clr wins.
module crp_result_reg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          clr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q
);
    // Capture a finished result, or clear it on reset or initialization.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (load)     q <= din;
    end
endmodule

// File: rtl/crp_out_lane.sv
// Module: crp_out_lane
// Applies output coding and byte-lane ordering, then gates the bus.
// Assumes: DW is a multiple of 8; a swap reverses the byte-lane order.
module crp_out_lane #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] result,
    input  logic          twos_comp,
    input  logic          swap_bytes,
    input  logic          sel_n,
    input  logic          rd_n,
    input  logic          kill,
    output logic [DW-1:0] bus_val,
    output logic          bus_oe
);
    localparam int NB = DW / 8;

    logic [DW-1:0] coded;
    logic [DW-1:0] laned;

    // Two's complement is offset binary with the top bit flipped.
    always_comb begin
        coded = {result[DW-1] ^ twos_comp, result[DW-2:0]};
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        // Route one byte lane, straight or mirrored.
        always_comb begin
            laned[g*8 +: 8] = swap_bytes ? coded[(NB-1-g)*8 +: 8]
                                         : coded[g*8 +: 8];
        end
    end

    // Drive the pads only when selected, reading, and not in reset.
    always_comb begin
        bus_oe  = !sel_n && !rd_n && !kill;
        bus_val = bus_oe ? laned : '0;
    end
endmodule

// File: rtl/conv_result_port.sv
// Module: conv_result_port (top)
// Parallel result port of a sampling converter: result holding,
// coding, lane swap, bus enable, and BUSY/device-reset sequencing.
// Assumes: all inputs are synchronous to clk; the pad ring turns
// bus_val/bus_oe into a tri-state bus.
module conv_result_port
    import crp_pkg::*;
#(
    parameter int DW          = 16,
    parameter int INIT_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dev_reset,
    input  logic          conv_start,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_word,
    input  logic          sel_n,
    input  logic          rd_n,
    input  logic          swap_bytes,
    input  logic          twos_comp,
    output logic [DW-1:0] bus_val,
    output logic          bus_oe,
    output logic          busy
);
    phase_t        phase;
    logic          load_en;
    logic          clr_en;
    logic          kill;
    logic          rise;
    logic [DW-1:0] result;

    crp_seq #(.INIT_CYCLES(INIT_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_reset  (dev_reset),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .phase      (phase),
        .busy       (busy),
        .load_en    (load_en),
        .clr_en     (clr_en),
        .kill       (kill),
        .rise       (rise)
    );

    crp_result_reg #(.DW(DW)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_en),
        .clr   (clr_en),
        .din   (conv_word),
        .q     (result)
    );

    crp_out_lane #(.DW(DW)) u_out (
        .result     (result),
        .twos_comp  (twos_comp),
        .swap_bytes (swap_bytes),
        .sel_n      (sel_n),
        .rd_n       (rd_n),
        .kill       (kill),
        .bus_val    (bus_val),
        .bus_oe     (bus_oe)
    );
endmodule

// File: rtl/conv_result_port_chk.sv
// Module: conv_result_port_chk
// Protocol checks for conv_result_port, attached with bind.
module conv_result_port_chk
    import crp_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dev_reset,
    input logic          conv_start,
    input logic          conv_done,
    input logic [DW-1:0] conv_word,
    input logic          sel_n,
    input logic          rd_n,
    input logic          bus_oe,
    input logic          busy,
    input phase_t        phase,
    input logic          clr_en,
    input logic          rise,
    input logic [DW-1:0] result
);
    AST_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || rd_n) |-> !bus_oe);                                   // R1
    AST_HIZ_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |-> !bus_oe);                                         // R4
    AST_INIT_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> busy);                                               // R5
    AST_NO_START_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INIT && conv_start) |=> phase != PH_CONV);         // R6
    AST_DONE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV && conv_done && !rise && !clr_en)
            |=> result == $past(conv_word));                            // R7
    AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_CONV && !clr_en) |=> $stable(result));             // R8
endmodule

bind conv_result_port conv_result_port_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_reset  (dev_reset),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .conv_word  (conv_word),
    .sel_n      (sel_n),
    .rd_n       (rd_n),
    .bus_oe     (bus_oe),
    .busy       (busy),
    .phase      (phase),
    .clr_en     (clr_en),
    .rise       (rise),
    .result     (result)
);

// File: tb/sim_conv_result_port.sv
module sim_conv_result_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_reset = 1'b0;
    logic        conv_start = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] conv_word = '0;
    logic        sel_n = 1'b0;
    logic        rd_n = 1'b0;
    logic        swap_bytes = 1'b0;
    logic        twos_comp = 1'b0;
    logic [15:0] bus_val;
    logic        bus_oe;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    conv_result_port u0 (
        .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset),
        .conv_start(conv_start), .conv_done(conv_done), .conv_word(conv_word),
        .sel_n(sel_n), .rd_n(rd_n), .swap_bytes(swap_bytes),
        .twos_comp(twos_comp), .bus_val(bus_val), .bus_oe(bus_oe), .busy(busy)
    );

    // Fields, high to low: {word, twos_comp, swap_bytes, expected bus}.
    localparam logic [33:0] VEC [8] = '{
        {16'h1234, 1'b0, 1'b0, 16'h1234},   // R2 R3 plain
        {16'h1234, 1'b0, 1'b1, 16'h3412},   // R3 swapped
        {16'h1234, 1'b1, 1'b0, 16'h9234},   // R2 MSB flipped
        {16'h1234, 1'b1, 1'b1, 16'h3492},   // R2 R3 both
        {16'hFF00, 1'b0, 1'b0, 16'hFF00},
        {16'h80A5, 1'b1, 1'b1, 16'hA500},
        {16'h0001, 1'b1, 1'b0, 16'h8001},
        {16'hABCD, 1'b0, 1'b1, 16'hCDAB}
    };

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Start a conversion, then complete it with word w. Returns at a negedge
    // with the new result already loaded.
    task automatic run_conv(input logic [15:0] w);
        @(negedge clk); conv_start = 1'b1;
        @(negedge clk); conv_start = 1'b0;
        conv_word = w; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        finish_run();
    end

    initial begin
        int hi_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R9 busy after reset", {15'd0, busy}, 16'h0);
        check(bus_oe == 1'b1 && bus_val == 16'h0, "R9 result zero",
              bus_val, 16'h0);

        // Table walk over coding and lane-order combinations.
        for (int i = 0; i < 8; i++) begin
            twos_comp  = VEC[i][17];
            swap_bytes = VEC[i][16];
            run_conv(VEC[i][33:18]);
            check(bus_val == VEC[i][15:0], "R2/R3 vector", bus_val, VEC[i][15:0]);
        end
        twos_comp = 1'b0; swap_bytes = 1'b0;

        // R7: read during conversion shows the previous word; done updates it.
        @(negedge clk); conv_start = 1'b1;
        @(negedge clk); conv_start = 1'b0;
        check(busy == 1'b1, "R7 busy in conversion", {15'd0, busy}, 16'h1);
        check(bus_val == 16'hABCD, "R7 previous result", bus_val, 16'hABCD);
        conv_word = 16'h5555; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        check(busy == 1'b0, "R7 busy drops", {15'd0, busy}, 16'h0);
        check(bus_val == 16'h5555, "R7 continuous update", bus_val, 16'h5555);

        // R8: a stray done while idle is ignored.
        conv_word = 16'h7777; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        @(negedge clk);
        check(bus_val == 16'h5555, "R8 stray done", bus_val, 16'h5555);

        // R4: device reset during a conversion.
        conv_start = 1'b1;
        @(negedge clk); conv_start = 1'b0;
        dev_reset = 1'b1;
        #1;
        check(bus_oe == 1'b0, "R4 immediate release", {15'd0, bus_oe}, 16'h0);
        @(negedge clk);
        conv_word = 16'h1111; conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        check(busy == 1'b0, "R4 busy aborted", {15'd0, busy}, 16'h0);
        check(bus_oe == 1'b0, "R4 bus released in hold", {15'd0, bus_oe}, 16'h0);

        // R5/R6: falling edge, init pulse, start during init ignored.
        @(negedge clk);
        dev_reset = 1'b0; conv_start = 1'b1;
        hi_cnt = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (busy) hi_cnt++;
            if (k == 1)
                check(bus_oe && bus_val == 16'h0, "R5 result cleared", bus_val, 16'h0);
            if (k == 3) conv_start = 1'b0;
            if (k == 5)
                check(busy == 1'b0, "R6 start in init ignored", {15'd0, busy}, 16'h0);
        end
        check(hi_cnt == 4, "R5 init pulse length", 16'(hi_cnt), 16'd4);

        // R2: the cleared word in two's complement.
        twos_comp = 1'b1;
        #1;
        check(bus_val == 16'h8000, "R2 zero coded", bus_val, 16'h8000);
        twos_comp = 1'b0;

        // R1: select and read gating.
        sel_n = 1'b1; #1;
        check(bus_oe == 1'b0 && bus_val == 16'h0, "R1 sel_n high", bus_val, 16'h0);
        sel_n = 1'b0; rd_n = 1'b1; #1;
        check(bus_oe == 1'b0, "R1 rd_n high", {15'd0, bus_oe}, 16'h0);
        rd_n = 1'b0; #1;
        check(bus_oe == 1'b1, "R1 both low", {15'd0, bus_oe}, 16'h1);

        // R9: system reset clears a loaded result.
        run_conv(16'h4321);
        check(bus_val == 16'h4321, "R7 load before reset", bus_val, 16'h4321);
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(bus_val == 16'h0 && busy == 1'b0, "R9 reset clears", bus_val, 16'h0);

        finish_run();
    end
endmodule